// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Router

This block sits between a set of device interrupt sources and four processors. Each cycle it captures a 64-bit vector of raw device requests into a shared register. Every CPU has its own 64-bit mask. The masked view that CPU sees is the bitwise AND of its mask with the captured raw vector. Each CPU gets one level-sensitive device interrupt line, which is high whenever any bit of its masked view is set.

Software reaches the block through a 64-bit register port. It can read the raw vector, each mask and each masked view, and it can write the masks. When a mask write lands, the block compares the old and new masked vectors, but only at the bit positions whose mask value changed. From that comparison it raises a one-cycle post pulse when a newly enabled bit carries a live request. It raises a one-cycle release pulse when a bit that was driving the line stops driving it. Accesses that are not full 64-bit, writes to read-only registers and accesses to unmapped indices are answered with an error.

Top module: `irq_mask_router`

## Requirements
- R1: After reset, all masks, the raw vector, all interrupt lines and all pulses are zero, and reads of every mapped register return zero.
- R2: The raw register captures `raw_req_i` at every clock edge and is read at register index 0.
- R3: A full-width write to index 1+c stores the write data as the mask of CPU c, and a read of index 1+c returns it.
- R4: A read of index 5+c returns the mask of CPU c ANDed with the raw register.
- R5: `irq_o[c]` equals the OR of all bits of CPU c's masked view, and it follows a mask write or a raw change at the same clock edge that updates the register.
- R6: A mask write raises `post_o[c]` for one cycle when some bit position whose mask value changed has both the new mask bit and the new raw bit set.
- R7: A mask write raises `release_o[c]` for one cycle when some bit position whose mask value changed was set in the old masked view and is clear in the new one.
- R8: A mask write that leaves the mask value unchanged raises no pulse and leaves `irq_o` unchanged.
- R9: The register index is the byte offset shifted right by 6. Address bits 5:0 are ignored.
- R10: `req_size` encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. Any size other than 3 returns an error, has no effect on state and reads as zero.
- R11: A write to the raw register or to a masked-view register returns an error and changes no state.
- R12: An access to an index above 8 returns an error, and a read there returns zero.
- R13: Every request gives exactly one response, with `rsp_valid` high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_req_i | input | 64 | Raw device request levels, captured every cycle |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset from block base |
| req_size | input | 2 | Access width code (3 = 64-bit) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 64 | Read data, zero on writes and errors |
| irq_o | output | 4 | Per-CPU device interrupt level |
| post_o | output | 4 | Per-CPU one-cycle post event from a mask write |
| release_o | output | 4 | Per-CPU one-cycle release event from a mask write |

## Verification
A mask write and a change of the raw vector can land on the same clock edge. The edge comparison must then use the incoming raw value for the new masked view and the held raw value for the old one. The bench provokes this by driving a new raw vector in the cycle of a mask write that moves the enable from one live bit to another. In that cycle the old bit is live only in the old raw vector and the new bit only in the incoming one. The bench expects both a post pulse and a release pulse, the line to stay high, and a following read of the masked view to show the new bit alone.

// File: rtl/irq_mask_router_pkg.sv
// Shared constants and types for the per-CPU device interrupt mask router.
// Assumes a 64-bit data path and registers spaced 64 bytes apart.
package irq_mask_router_pkg;

    localparam int DATA_W    = 64;
    localparam int OFS_SHIFT = 6;

    // Access width code for a full 64-bit access
    localparam logic [1:0] SZ_DWORD = 2'd3;

    // Kind of register selected by a decoded index
    typedef enum logic [1:0] {
        RK_RAW    = 2'd0,
        RK_MASK   = 2'd1,
        RK_MASKED = 2'd2,
        RK_NONE   = 2'd3
    } reg_kind_t;

endpackage

// File: rtl/irq_reg_decode.sv
// Register index decoder.
// Turns a byte offset and access width into a register kind, a CPU number,
// an error flag and a mask write enable. Index layout: 0 raw vector,
// 1..N_CPU masks, N_CPU+1..2*N_CPU masked views, everything else unmapped.
// Assumes the caller qualifies all outputs with req_valid.
module irq_reg_decode
    import irq_mask_router_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int ADDR_W = 12,
    parameter int CPU_W  = 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output reg_kind_t         kind,
    output logic [CPU_W-1:0]  cpu_sel,
    output logic              acc_err,
    output logic              mask_we
);
    localparam int IDX_W = ADDR_W - OFS_SHIFT;

    logic [IDX_W-1:0] idx;
    logic             size_ok;

    assign idx     = req_addr[ADDR_W-1:OFS_SHIFT];
    assign size_ok = (req_size == SZ_DWORD);

    // Map the index onto a register kind and CPU number
    always_comb begin
        kind    = RK_NONE;
        cpu_sel = '0;
        if (idx == '0) begin
            kind = RK_RAW;
        end else if (idx <= IDX_W'(N_CPU)) begin
            kind    = RK_MASK;
            cpu_sel = CPU_W'(idx - IDX_W'(1));
        end else if (idx <= IDX_W'(2 * N_CPU)) begin
            kind    = RK_MASKED;
            cpu_sel = CPU_W'(idx - IDX_W'(N_CPU + 1));
        end
    end

    // Classify the access as legal or not and derive the mask write strobe
    always_comb begin
        acc_err = 1'b0;
        if (req_valid) begin
            if (!size_ok || kind == RK_NONE) begin
                acc_err = 1'b1;
            end else if (req_write && kind != RK_MASK) begin
                acc_err = 1'b1;
            end
        end
        mask_we = req_valid && req_write && !acc_err && (kind == RK_MASK);
    end

endmodule

// File: rtl/irq_cpu_slice.sv
// One CPU's mask register, masked view, level output and edge events.
// On a write the old and new masked vectors are compared only where the
// mask changed. The new view uses the raw value being captured this edge
// and the old view uses the raw value held until now.
// Assumes raw_q and raw_next come from the shared raw register.
module irq_cpu_slice
    import irq_mask_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] raw_q,
    input  logic [DATA_W-1:0] raw_next,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] masked,
    output logic              irq_q,
    output logic              post_q,
    output logic              rel_q
);
    logic [DATA_W-1:0] mask_next;
    logic [DATA_W-1:0] masked_old;
    logic [DATA_W-1:0] masked_next;
    logic [DATA_W-1:0] changed;
    logic [DATA_W-1:0] set_hits;
    logic [DATA_W-1:0] rel_hits;

    // Next mask value and the bit-by-bit comparison of old and new views
    always_comb begin
        mask_next   = we ? wdata : mask_q;
        masked_old  = mask_q & raw_q;
        masked_next = mask_next & raw_next;
        changed     = mask_q ^ mask_next;
        set_hits    = changed & mask_next & masked_next;
        rel_hits    = changed & masked_old & ~masked_next;
    end

    // Current masked view for register reads
    assign masked = masked_old;

    // Mask storage, level output and the one-cycle edge events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
            post_q <= 1'b0;
            rel_q  <= 1'b0;
        end else begin
            mask_q <= mask_next;
            irq_q  <= |masked_next;
            post_q <= we && (|set_hits);
            rel_q  <= we && (|rel_hits);
        end
    end

endmodule

// File: rtl/irq_read_mux.sv
// Read data selector.
// Picks the raw vector, one CPU's mask or one CPU's masked view from the
// decoded kind and CPU number. Unmapped kinds read as zero.
module irq_read_mux
    import irq_mask_router_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int CPU_W = 2
) (
    input  reg_kind_t                      kind,
    input  logic [CPU_W-1:0]               cpu_sel,
    input  logic [DATA_W-1:0]              raw_q,
    input  logic [N_CPU-1:0][DATA_W-1:0]   mask_q,
    input  logic [N_CPU-1:0][DATA_W-1:0]   masked,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] mask_pick;
    logic [DATA_W-1:0] masked_pick;

    // Select the addressed CPU's registers
    always_comb begin
        mask_pick   = '0;
        masked_pick = '0;
        for (int c = 0; c < N_CPU; c++) begin
            if (cpu_sel == CPU_W'(c)) begin
                mask_pick   = mask_q[c];
                masked_pick = masked[c];
            end
        end
    end

    // Choose among register kinds
    always_comb begin
        unique case (kind)
            RK_RAW:    rdata = raw_q;
            RK_MASK:   rdata = mask_pick;
            RK_MASKED: rdata = masked_pick;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_mask_router.sv
// Per-CPU device interrupt mask router, top level.
// Holds the shared raw request register and one mask slice per CPU, and
// answers register accesses one cycle after each request.
// Assumes at most one request per cycle and no back-pressure.
module irq_mask_router
    import irq_mask_router_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       raw_req_i,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic [N_CPU-1:0]  irq_o,
    output logic [N_CPU-1:0]  post_o,
    output logic [N_CPU-1:0]  release_o
);
    localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    reg_kind_t                     kind;
    logic [CPU_W-1:0]              cpu_sel;
    logic                          acc_err;
    logic                          mask_we;
    logic [DATA_W-1:0]             raw_q;
    logic [N_CPU-1:0][DATA_W-1:0]  mask_q;
    logic [N_CPU-1:0][DATA_W-1:0]  masked;
    logic [DATA_W-1:0]             rd_sel;

    irq_reg_decode #(
        .N_CPU (N_CPU),
        .ADDR_W(ADDR_W),
        .CPU_W (CPU_W)
    ) u_dec (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .kind     (kind),
        .cpu_sel  (cpu_sel),
        .acc_err  (acc_err),
        .mask_we  (mask_we)
    );

    // Shared raw request capture, one sample per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_req_i;
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        irq_cpu_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (mask_we && (cpu_sel == CPU_W'(c))),
            .wdata   (req_wdata),
            .raw_q   (raw_q),
            .raw_next(raw_req_i),
            .mask_q  (mask_q[c]),
            .masked  (masked[c]),
            .irq_q   (irq_o[c]),
            .post_q  (post_o[c]),
            .rel_q   (release_o[c])
        );
    end

    irq_read_mux #(
        .N_CPU(N_CPU),
        .CPU_W(CPU_W)
    ) u_rmux (
        .kind   (kind),
        .cpu_sel(cpu_sel),
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .masked (masked),
        .rdata  (rd_sel)
    );

    // Registered response: strobe, error and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_err;
            rsp_rdata <= (req_valid && !req_write && !acc_err) ? rd_sel : '0;
        end
    end

endmodule

// File: rtl/irq_mask_router_chk.sv
// Checker for the mask router, bound to every instance of the top.
// Relates the response port, the stored masks, the raw register and the
// per-CPU outputs over time.
module irq_mask_router_chk #(
    parameter int N_CPU = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [1:0]               req_size,
    input logic                     rsp_valid,
    input logic                     rsp_err,
    input logic [63:0]              raw_q,
    input logic [N_CPU-1:0][63:0]   mask_q,
    input logic [N_CPU-1:0]         irq_o,
    input logic [N_CPU-1:0]         post_o,
    input logic [N_CPU-1:0]         release_o
);
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R13

    AST_NARROW_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'd3) |=> rsp_err); // R10

    AST_ERR_KEEPS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (mask_q == $past(mask_q))); // R11

    for (genvar c = 0; c < N_CPU; c++) begin : g_chk
        AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] == (|(mask_q[c] & raw_q))); // R5

        AST_POST_WITH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
            post_o[c] |-> irq_o[c]); // R6

        AST_QUIET_WHEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(mask_q[c]) |-> (!post_o[c] && !release_o[c])); // R8
    end

endmodule

bind irq_mask_router irq_mask_router_chk #(.N_CPU(N_CPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_size (req_size),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .irq_o    (irq_o),
    .post_o   (post_o),
    .release_o(release_o)
);

// File: tb/irq_mask_router_test.sv
`timescale 1ns/1ps
module irq_mask_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] raw_req_i = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'd3;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic [3:0]  irq_o;
    logic [3:0]  post_o;
    logic [3:0]  release_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_mask_router uut (
        .clk(clk), .rst_n(rst_n), .raw_req_i(raw_req_i),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .irq_o(irq_o), .post_o(post_o), .release_o(release_o)
    );

    function automatic logic [11:0] a_of(input int idx);
        return 12'(idx << 6);
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // One access; returns at the negedge after the response edge
    task automatic acc(input logic wr, input logic [11:0] addr, input logic [1:0] sz,
                       input logic [63:0] wd, output logic [63:0] rd, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; err = rsp_err;
    endtask

    task automatic set_raw(input logic [63:0] v);
        @(negedge clk);
        raw_req_i = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] rd; logic e;
        chk("R1 irq after reset", 64'(irq_o), 64'h0);
        chk("R1 post after reset", 64'(post_o | release_o), 64'h0);
        acc(1'b0, a_of(0), 2'd3, 0, rd, e);
        chk("R1 raw read", rd, 64'h0);
        acc(1'b0, a_of(1), 2'd3, 0, rd, e);
        chk("R1 mask0 read", rd, 64'h0);
        acc(1'b0, a_of(8), 2'd3, 0, rd, e);
        chk("R1 masked3 read", rd, 64'h0);
    endtask

    task automatic t_raw();
        logic [63:0] rd; logic e;
        set_raw(64'hDEAD_0000_0000_0001);
        acc(1'b0, a_of(0), 2'd3, 0, rd, e);
        chk("R2 raw capture", rd, 64'hDEAD_0000_0000_0001);
        acc(1'b0, a_of(0) | 12'h03C, 2'd3, 0, rd, e);
        chk("R9 low offset bits ignored", rd, 64'hDEAD_0000_0000_0001);
        chk("R9 no error", 64'(e), 64'h0);
        set_raw(64'h0);
    endtask

    task automatic t_mask_rw();
        logic [63:0] rd; logic e;
        for (int c = 0; c < 4; c++) begin
            acc(1'b1, a_of(1 + c), 2'd3, 64'h1111_2222_3333_0000 << c, rd, e);
            chk("R3 write no error", 64'(e), 64'h0);
        end
        for (int c = 0; c < 4; c++) begin
            acc(1'b0, a_of(1 + c), 2'd3, 0, rd, e);
            chk("R3 mask readback", rd, 64'h1111_2222_3333_0000 << c);
        end
        chk("R5 no irq with raw zero", 64'(irq_o), 64'h0);
    endtask

    task automatic t_masked();
        logic [63:0] rd; logic e;
        logic [63:0] rv = 64'h0000_00F0_0000_0F0F;
        for (int c = 0; c < 4; c++)
            acc(1'b1, a_of(1 + c), 2'd3, 64'h0000_0010_0000_0001 << c, rd, e);
        set_raw(rv);
        for (int c = 0; c < 4; c++) begin
            acc(1'b0, a_of(5 + c), 2'd3, 0, rd, e);
            chk("R4 masked view", rd, rv & (64'h0000_0010_0000_0001 << c));
        end
        chk("R5 irq level from raw", 64'(irq_o), 64'hF);
        set_raw(64'h0000_0000_0000_0F00);
        chk("R5 irq follows raw drop", 64'(irq_o), 64'h0);
        for (int c = 0; c < 4; c++)
            acc(1'b1, a_of(1 + c), 2'd3, 64'h0, rd, e);
    endtask

    task automatic t_post();
        logic [63:0] rd; logic e;
        set_raw(64'h8000_0000_0000_0004);
        acc(1'b1, a_of(1), 2'd3, 64'h4, rd, e);
        chk("R6 post on enable", 64'(post_o), 64'h1);
        chk("R5 irq on enable", 64'(irq_o), 64'h1);
        acc(1'b1, a_of(1), 2'd3, 64'h8000_0000_0000_0004, rd, e);
        chk("R6 post on second bit", 64'(post_o), 64'h1);
        acc(1'b1, a_of(2), 2'd3, 64'h10, rd, e);
        chk("R6 no post without request", 64'(post_o), 64'h0);
        chk("R5 cpu1 line low", 64'(irq_o), 64'h1);
    endtask

    task automatic t_release();
        logic [63:0] rd; logic e;
        acc(1'b1, a_of(1), 2'd3, 64'h4, rd, e);
        chk("R7 release on partial disable", 64'(release_o), 64'h1);
        chk("R7 no post on disable", 64'(post_o), 64'h0);
        chk("R7 line stays with other bit", 64'(irq_o), 64'h1);
        acc(1'b1, a_of(1), 2'd3, 64'h0, rd, e);
        chk("R7 release on full disable", 64'(release_o), 64'h1);
        chk("R7 line drops", 64'(irq_o), 64'h0);
    endtask

    task automatic t_same();
        logic [63:0] rd; logic e;
        acc(1'b1, a_of(1), 2'd3, 64'h4, rd, e);
        acc(1'b1, a_of(1), 2'd3, 64'h4, rd, e);
        chk("R8 no pulse on same value", 64'(post_o | release_o), 64'h0);
        chk("R8 line unchanged", 64'(irq_o), 64'h1);
    endtask

    task automatic t_collision();
        logic [63:0] rd; logic e;
        acc(1'b1, a_of(1), 2'd3, 64'h1, rd, e);
        set_raw(64'h1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a_of(1); req_size = 2'd3;
        req_wdata = 64'h2; raw_req_i = 64'h2;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 post with same-edge raw", 64'(post_o), 64'h1);
        chk("R7 release with same-edge raw", 64'(release_o), 64'h1);
        chk("R5 line held across swap", 64'(irq_o), 64'h1);
        acc(1'b0, a_of(5), 2'd3, 0, rd, e);
        chk("R4 masked after swap", rd, 64'h2);
    endtask

    task automatic t_narrow();
        logic [63:0] rd; logic e;
        acc(1'b1, a_of(1), 2'd2, 64'hFF, rd, e);
        chk("R10 narrow write error", 64'(e), 64'h1);
        acc(1'b0, a_of(1), 2'd3, 0, rd, e);
        chk("R10 mask untouched", rd, 64'h2);
        acc(1'b0, a_of(1), 2'd0, 0, rd, e);
        chk("R10 narrow read error", 64'(e), 64'h1);
        chk("R10 narrow read zero", rd, 64'h0);
    endtask

    task automatic t_ro();
        logic [63:0] rd; logic e;
        acc(1'b1, a_of(0), 2'd3, 64'h55, rd, e);
        chk("R11 raw write error", 64'(e), 64'h1);
        acc(1'b0, a_of(0), 2'd3, 0, rd, e);
        chk("R11 raw unchanged", rd, 64'h2);
        acc(1'b1, a_of(5), 2'd3, 64'hFF, rd, e);
        chk("R11 masked write error", 64'(e), 64'h1);
        acc(1'b0, a_of(1), 2'd3, 0, rd, e);
        chk("R11 mask unchanged", rd, 64'h2);
    endtask

    task automatic t_unmapped();
        logic [63:0] rd; logic e;
        acc(1'b0, a_of(9), 2'd3, 0, rd, e);
        chk("R12 unmapped read error", 64'(e), 64'h1);
        chk("R12 unmapped read zero", rd, 64'h0);
        chk("R13 response strobe", 64'(rsp_valid), 64'h1);
        @(negedge clk);
        chk("R13 strobe single cycle", 64'(rsp_valid), 64'h0);
        acc(1'b1, a_of(40), 2'd3, 64'h1, rd, e);
        chk("R12 unmapped write error", 64'(e), 64'h1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw();
        t_mask_rw();
        t_masked();
        t_post();
        t_release();
        t_same();
        t_collision();
        t_narrow();
        t_ro();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule